// File: doc/BRIEF.md
# Flash Page Program Buffer

This block gathers the data bytes of one page-program command into a page-sized staging buffer. It then hands the finished page to a simple page-array write port. A front end has already decoded the serial command. It presents a start address, then one strobe for each data byte received, then an end strobe. The end strobe carries a flag that says whether the command stopped exactly on a byte boundary. An abort strobe lets the front end drop a command, for example after a protection reject.

Bytes land at consecutive offsets inside one 256-byte page, beginning at the low address byte. When they run past the top of the page they fold back to offset 0 of the same page. A per-offset written-map records which offsets received data. At commit the block reads the page's current contents from the array. It presents a merged image in which written offsets hold the old byte ANDed with the new one, because programming can only clear bits. Offsets that were not written hold the old byte unchanged. The request stays raised until the array reports that it is done, and all front-end traffic is dropped meanwhile.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset `commitReq` is low and stays low until a command has completed with at least one byte.
- R2: The committed page index is `startAddr[18:8]`; address bits 23 to 19 have no effect.
- R3: Data bytes are stored at offsets `startAddr[7:0]`, +1, +2, and so on. After offset 255 the next byte goes to offset 0 of the same page.
- R4: When more than 256 bytes arrive, each offset holds the last byte written to it, so the final 256 bytes are the ones committed.
- R5: In `commitData`, every offset not written by the command equals the corresponding byte of `pageRdData`. Offset k occupies bits `8k+7:8k`.
- R6: In `commitData`, every written offset equals the `pageRdData` byte ANDed with the received byte, so no bit ever goes from 0 to 1.
- R7: A commit is raised only when `cmdEnd` arrives with `endAligned`=1 and at least one byte was received. Otherwise the command is discarded, and none of its bytes appear in any later commit.
- R8: `abort` during a command discards it; no commit follows.
- R9: `commitReq` stays high until the cycle in which `arrayDone` is sampled high, and it is low on the next cycle. While it is high, `cmdStart`, `byteValid`, `cmdEnd` and `abort` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Begin a program command; latches `startAddr` |
| startAddr | input | 24 | Command byte address; bits 23..19 ignored |
| byteValid | input | 1 | One data byte present on `byteData` |
| byteData | input | 8 | Received data byte |
| cmdEnd | input | 1 | Command ended (select released) |
| endAligned | input | 1 | Qualifies `cmdEnd`: 1 when the end fell on a byte boundary |
| abort | input | 1 | Drop the current command without commit |
| pageRdData | input | 2048 | Current array contents of page `commitPage` |
| arrayDone | input | 1 | Array finished the requested page write |
| commitReq | output | 1 | Merged page is ready for writing |
| commitPage | output | 11 | Page index for read and write |
| commitData | output | 2048 | Merged page image to be written |

## Verification
The bench goes after four failure modes. The first is the fold-back at the page top: a design that carries into the next page would commit to the wrong index, or would leave offsets 0 and 1 untouched. The second is a stream longer than a page: keeping the first bytes instead of the last would show wrong values at the offsets that were written twice. The third is programming over an already programmed page: replacing bytes instead of ANDing them would set cleared bits again, and a bad mask would corrupt neighbouring offsets. The fourth covers an unaligned end, an abort, an empty command and traffic sent while a commit waits. A design that leaks any of these would show a commit the scoreboard never expected, or stale bytes inside a later one.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2
  } ppb_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic clearMap;
    logic writeByte;
  } ppb_strobe_t;

endpackage

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
  import ppb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        byteValid,
  input  logic        cmdEnd,
  input  logic        endAligned,
  input  logic        abort,
  input  logic        arrayDone,
  input  logic        anyWritten,
  output ppb_strobe_t stb,
  output logic        commitReq
);

  ppb_state_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          stb.loadAddr = 1'b1;
          stb.clearMap = 1'b1;
          nextState    = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (abort) begin
          stb.clearMap = 1'b1;
          nextState    = ST_IDLE;
        end else if (cmdEnd) begin
          if (endAligned && anyWritten) begin
            nextState = ST_COMMIT;
          end else begin
            stb.clearMap = 1'b1;
            nextState    = ST_IDLE;
          end
        end else if (cmdStart) begin
          stb.loadAddr = 1'b1;
          stb.clearMap = 1'b1;
        end else if (byteValid) begin
          stb.writeByte = 1'b1;
        end
      end
      ST_COMMIT: begin
        if (arrayDone) begin
          stb.clearMap = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign commitReq = (state == ST_COMMIT);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    commitReq && !arrayDone |=> commitReq); // R9
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    commitReq && arrayDone |=> !commitReq); // R9
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COLLECT) && abort |=> !commitReq); // R8
  AST_UNALIGNED_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COLLECT) && !abort && cmdEnd && !endAligned |=> !commitReq); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !commitReq); // R1

endmodule

// File: rtl/ppb_datapath.sv
module ppb_datapath
  import ppb_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_W     = 11,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int LOC_W     = PAGE_W + OFF_W,
  localparam int PAGE_BITS = PAGE_BYTES * 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ppb_strobe_t          stb,
  input  logic [LOC_W-1:0]     startLoc,
  input  logic [7:0]           byteData,
  input  logic [PAGE_BITS-1:0] pageRdData,
  output logic [PAGE_W-1:0]    commitPage,
  output logic [PAGE_BITS-1:0] commitData,
  output logic                 anyWritten
);

  logic [PAGE_W-1:0]     pageIdx;
  logic [OFF_W-1:0]      wrOff;
  logic [PAGE_BYTES-1:0] validMap;
  logic [7:0]            bufMem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageIdx  <= '0;
      wrOff    <= '0;
      validMap <= '0;
    end else begin
      if (stb.loadAddr) begin
        pageIdx <= startLoc[LOC_W-1:OFF_W];
        wrOff   <= startLoc[OFF_W-1:0];
      end
      if (stb.clearMap) begin
        validMap <= '0;
      end else if (stb.writeByte) begin
        validMap[wrOff] <= 1'b1;
        wrOff           <= wrOff + 1'b1;  // natural fold within the page
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.writeByte) bufMem[wrOff] <= byteData;
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_merge
      logic [7:0] oldByte;
      assign oldByte = pageRdData[g*8 +: 8];
      assign commitData[g*8 +: 8] = validMap[g] ? (oldByte & bufMem[g]) : oldByte;
    end
  endgenerate

  assign commitPage = pageIdx;
  assign anyWritten = |validMap;

  AST_MAP_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte && !stb.clearMap |=> validMap[$past(wrOff)]); // R3
  AST_MAP_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearMap |=> !anyWritten); // R7
  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadAddr |=> $stable(commitPage)); // R2
  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (commitData & ~pageRdData) == '0); // R6

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer
  import ppb_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ARRAY_BYTES = 524288,
  parameter int PAGE_BYTES  = 256,
  localparam int LOC_W      = $clog2(ARRAY_BYTES),
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = LOC_W - OFF_W,
  localparam int PAGE_BITS  = PAGE_BYTES * 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdStart,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic                 byteValid,
  input  logic [7:0]           byteData,
  input  logic                 cmdEnd,
  input  logic                 endAligned,
  input  logic                 abort,
  input  logic [PAGE_BITS-1:0] pageRdData,
  input  logic                 arrayDone,
  output logic                 commitReq,
  output logic [PAGE_W-1:0]    commitPage,
  output logic [PAGE_BITS-1:0] commitData
);

  ppb_strobe_t stb;
  logic        anyWritten;
  logic        unusedAddrHi;

  assign unusedAddrHi = ^startAddr[ADDR_W-1:LOC_W];

  ppb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .byteValid  (byteValid),
    .cmdEnd     (cmdEnd),
    .endAligned (endAligned),
    .abort      (abort),
    .arrayDone  (arrayDone),
    .anyWritten (anyWritten),
    .stb        (stb),
    .commitReq  (commitReq)
  );

  ppb_datapath #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startLoc   (startAddr[LOC_W-1:0]),
    .byteData   (byteData),
    .pageRdData (pageRdData),
    .commitPage (commitPage),
    .commitData (commitData),
    .anyWritten (anyWritten)
  );

endmodule

// File: tb/page_prog_buffer_tb.sv
`timescale 1ns/1ps
module page_prog_buffer_tb;

  localparam int BUSY = 6;
  localparam int PB   = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          cmdStart = 1'b0, byteValid = 1'b0, cmdEnd = 1'b0;
  logic          endAligned = 1'b0, abort = 1'b0, arrayDone = 1'b0;
  logic [23:0]   startAddr = '0;
  logic [7:0]    byteData = '0;
  logic [PB-1:0] pageRdData = '1;
  logic          commitReq;
  logic [10:0]   commitPage;
  logic [PB-1:0] commitData;

  page_prog_buffer u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .cmdEnd(cmdEnd),
    .endAligned(endAligned), .abort(abort), .pageRdData(pageRdData),
    .arrayDone(arrayDone), .commitReq(commitReq), .commitPage(commitPage),
    .commitData(commitData)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Array model and reference image
  logic [PB-1:0] arrMem [int];
  logic [PB-1:0] refMem [int];

  function automatic logic [PB-1:0] arrRead(input int p);
    return arrMem.exists(p) ? arrMem[p] : {PB{1'b1}};
  endfunction
  function automatic logic [PB-1:0] refRead(input int p);
    return refMem.exists(p) ? refMem[p] : {PB{1'b1}};
  endfunction

  typedef struct { logic [10:0] page; logic [PB-1:0] data; string req; } exp_t;
  exp_t expQ [$];

  logic inFlight = 1'b0;
  int   busyCnt  = 0;

  always @(posedge clk) begin
    arrayDone <= 1'b0;
    if (inFlight) begin
      if (busyCnt == BUSY) begin
        arrMem[int'(commitPage)] = commitData;
        inFlight  <= 1'b0;
        arrayDone <= 1'b1;
      end else begin
        busyCnt <= busyCnt + 1;
      end
    end else if (commitReq && !arrayDone) begin
      inFlight <= 1'b1;
      busyCnt  <= 0;
    end
  end

  // Monitor: compares the image just before the array takes it
  always @(negedge clk) begin
    pageRdData <= arrRead(int'(commitPage));
    if (inFlight && busyCnt == BUSY) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected commit page", 32'(commitPage), 32'hFFFF);
      end else begin
        exp_t e;
        int   diff;
        e = expQ.pop_front();
        check(commitPage == e.page, e.req, "commit page", 32'(commitPage), 32'(e.page));
        diff = -1;
        for (int i = PB/8 - 1; i >= 0; i--)
          if (commitData[i*8 +: 8] !== e.data[i*8 +: 8]) diff = i;
        if (diff < 0)
          check(1'b1, e.req, "commit data", 0, 0);
        else
          check(1'b0, e.req, $sformatf("commit data offset %0d", diff),
                32'(commitData[diff*8 +: 8]), 32'(e.data[diff*8 +: 8]));
      end
    end
  end

  // Driver side model of the current command
  logic [7:0]  cmdImg   [256];
  bit          cmdTouch [256];
  logic [10:0] cmdPage;
  logic [7:0]  cmdOff;

  task automatic startCmd(input logic [23:0] a);
    cmdStart = 1'b1; startAddr = a;
    @(negedge clk);
    cmdStart = 1'b0;
    for (int i = 0; i < 256; i++) cmdTouch[i] = 1'b0;
    cmdPage = a[18:8];
    cmdOff  = a[7:0];
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
    cmdImg[cmdOff]   = d;
    cmdTouch[cmdOff] = 1'b1;
    cmdOff = cmdOff + 8'd1;
  endtask

  task automatic endCmd(input bit aligned, input string req);
    bit            any;
    logic [PB-1:0] img;
    cmdEnd = 1'b1; endAligned = aligned;
    @(negedge clk);
    cmdEnd = 1'b0; endAligned = 1'b0;
    any = 1'b0;
    img = refRead(int'(cmdPage));
    for (int i = 0; i < 256; i++)
      if (cmdTouch[i]) begin
        any = 1'b1;
        img[i*8 +: 8] = img[i*8 +: 8] & cmdImg[i];
      end
    if (aligned && any) begin
      exp_t e;
      e.page = cmdPage; e.data = img; e.req = req;
      expQ.push_back(e);
      refMem[int'(cmdPage)] = img;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 100; i++) begin
      if (expQ.size() == 0 && !commitReq && !inFlight) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idleCheck(input string req, input string what);
    repeat (BUSY + 8) @(negedge clk);
    check(!commitReq && !inFlight, req, what, 32'(commitReq), 0);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(commitReq == 1'b0, "R1", "commitReq in reset", 32'(commitReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(commitReq == 1'b0, "R1", "commitReq after reset", 32'(commitReq), 0);

    // R2: high address bits set, page from bits 18:8
    startCmd(24'hF81234);
    sendByte(8'h3C); sendByte(8'hA5); sendByte(8'h5A); sendByte(8'h0F);
    endCmd(1'b1, "R2");
    drain();

    // R3: fold from offset FE to 0..2 of the same page
    startCmd(24'h0207FE);
    for (int i = 0; i < 5; i++) sendByte(8'(8'hE0 + i));
    endCmd(1'b1, "R3");
    drain();

    // R4: 300 bytes, last writer per offset wins
    startCmd(24'h030510);
    for (int i = 0; i < 300; i++) sendByte(8'(i * 7 + 3));
    endCmd(1'b1, "R4");
    drain();

    // R5/R6: program again over the R2 page, partial overlap
    startCmd(24'h001235);
    sendByte(8'hF0); sendByte(8'h33);
    endCmd(1'b1, "R6");
    drain();
    check(arrRead(12'h012)[8'h34*8 +: 8] == 8'h3C, "R5", "untouched byte kept",
          32'(arrRead(12'h012)[8'h34*8 +: 8]), 32'h3C);

    // R7: unaligned end discards; a later command sees none of it
    startCmd(24'h004400);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h00);
    endCmd(1'b0, "R7");
    idleCheck("R7", "no commit after unaligned end");
    startCmd(24'h004402);
    sendByte(8'h81);
    endCmd(1'b1, "R7");
    drain();

    // R7: aligned end with no data
    startCmd(24'h004500);
    endCmd(1'b1, "R7");
    idleCheck("R7", "no commit for empty command");

    // R8: abort
    startCmd(24'h004600);
    sendByte(8'h11); sendByte(8'h22);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    idleCheck("R8", "no commit after abort");
    check(arrRead(12'h046) == {PB{1'b1}}, "R8", "aborted page untouched", 0, 0);

    // R9: traffic while a commit waits is ignored
    startCmd(24'h0077F0);
    sendByte(8'h96);
    endCmd(1'b1, "R9");
    cmdStart = 1'b1; startAddr = 24'h007700; @(negedge clk); cmdStart = 1'b0;
    byteValid = 1'b1; byteData = 8'h00; @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    byteData = 8'h01; @(negedge clk); byteValid = 1'b0;
    cmdEnd = 1'b1; endAligned = 1'b1; @(negedge clk); cmdEnd = 1'b0; endAligned = 1'b0;
    drain();
    idleCheck("R9", "no stray commit after busy traffic");

    check(expQ.size() == 0, "R7", "pending expected commits", 32'(expQ.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule